// File: doc/BRIEF.md
# Register-Mapped Wrapper for a 64-bit Block Cipher Engine

This block lets a 32-bit memory-mapped bus master drive a block-cipher engine that has no address port of its own. The engine takes a 64-bit key, a 64-bit input block and a one-bit direction select. It is launched by a start pulse and answers with busy while it works and a one-cycle done strobe when its 64-bit output is ready. The wrapper keeps the key and the input block as pairs of 32-bit words written by the bus. It drives them onto the engine continuously, launches the engine on a write to a command word, and copies the engine output into a result buffer that the bus can read at any time.

Every bus access completes in the cycle it is presented, with no wait states. Read data is decoded combinationally from the address, and writes take effect at the clock edge that ends the access. A status word exposes the live busy line and a sticky completion flag, so software can poll for the end of an operation without catching the one-cycle done strobe.

Top module: `cipher_regwrap`

## Requirements
- R1: Byte address 0x00 holds key bits [63:32] and 0x04 holds key bits [31:0]; a write updates `eng_key` at the clock edge of the write, and a read returns the stored word.
- R2: Address 0x08 holds input bits [63:32] and 0x0C holds input bits [31:0]; they drive `eng_din` and read back the same way as the key.
- R3: Bit 0 of address 0x10 is the direction bit (1 = encrypt, 0 = decrypt). It drives `eng_mode` after the write edge and reads back in bit 0, with the other bits reading as zero.
- R4: A write to 0x14 while `eng_busy` is low and no start is already being issued makes `eng_start` high for exactly the one cycle that follows the write edge.
- R5: A write to 0x14 while `eng_busy` is high is ignored: `eng_start` stays low.
- R6: A read of 0x14 returns the status word, with bit 0 as the live `eng_busy` and bit 1 as a completion flag. The flag is set by `eng_done`, cleared at the edge of an accepted start, and all other bits read as zero.
- R7: The result buffer loads `eng_dout` at the edge where `eng_done` is high and holds it until the next done. Address 0x28 reads bits [63:32] and 0x2C reads bits [31:0].
- R8: Any address other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x28 and 0x2C reads as zero, and a write to it changes no register. Read data is valid in the same cycle as the address.
- R9: After reset, all registers, the completion flag, the result buffer and `eng_start` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, same cycle |
| eng_key | output | 2*DATA_W (64) | Key to engine |
| eng_din | output | 2*DATA_W (64) | Input block to engine |
| eng_mode | output | 1 | Direction select to engine |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_busy | input | 1 | Engine working |
| eng_done | input | 1 | Engine output valid strobe |
| eng_dout | input | 2*DATA_W (64) | Engine output block |

## Verification
The bench places a behavioural engine model with a fixed latency behind the wrapper and runs operations in both directions. It checks that each 32-bit half lands in the right part of the 64-bit operands and of the result. A design with the halves swapped would return the output words in the wrong order. A command written while the engine is busy must produce no pulse, where a naive design would restart the engine in the middle of an operation. The bench also requires the result buffer to keep the old result during a new run and the completion flag to drop at the accepted start, which catches a design that reads the live engine output or never clears the flag. It writes to unmapped and misaligned addresses and then reads back the real registers, so an incomplete address decode shows up as corrupted data.

// File: rtl/regwrap_pkg.sv
package regwrap_pkg;
   localparam int unsigned OFF_KEY_HI = 'h00;
   localparam int unsigned OFF_KEY_LO = 'h04;
   localparam int unsigned OFF_DIN_HI = 'h08;
   localparam int unsigned OFF_DIN_LO = 'h0C;
   localparam int unsigned OFF_MODE   = 'h10;
   localparam int unsigned OFF_CMD    = 'h14;
   localparam int unsigned OFF_RES_HI = 'h28;
   localparam int unsigned OFF_RES_LO = 'h2C;

   typedef struct packed {
      logic done_seen;
      logic busy;
   } stat_t;
endpackage

// File: rtl/cipher_halfreg.sv
module cipher_halfreg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/cipher_oppair.sv
module cipher_oppair #(
   parameter int HALF_W = 32,
   localparam int OP_W  = 2 * HALF_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      we,
   input  logic [OP_W-1:0] d,
   output logic [OP_W-1:0] q
);
   for (genvar g = 0; g < 2; g++) begin : g_half
      cipher_halfreg #(.W(HALF_W)) u_half (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (we[g]),
         .d     (d[g*HALF_W +: HALF_W]),
         .q     (q[g*HALF_W +: HALF_W])
      );
   end
endmodule

// File: rtl/cipher_ctrl.sv
module cipher_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr,
   input  logic eng_busy,
   input  logic eng_done,
   output logic start_q,
   output logic done_flag
);
   logic accept;
   assign accept = cmd_wr && !eng_busy && !start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= 1'b0;
         done_flag <= 1'b0;
      end else begin
         start_q <= accept;
         if (eng_done)    done_flag <= 1'b1;
         else if (accept) done_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/cipher_rddec.sv
module cipher_rddec
   import regwrap_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   localparam int OP_W  = 2 * DATA_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [OP_W-1:0]   key,
   input  logic [OP_W-1:0]   din,
   input  logic              mode,
   input  stat_t             stat,
   input  logic [OP_W-1:0]   res,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if      (addr == ADDR_W'(OFF_KEY_HI)) rdata = key[OP_W-1:DATA_W];
      else if (addr == ADDR_W'(OFF_KEY_LO)) rdata = key[DATA_W-1:0];
      else if (addr == ADDR_W'(OFF_DIN_HI)) rdata = din[OP_W-1:DATA_W];
      else if (addr == ADDR_W'(OFF_DIN_LO)) rdata = din[DATA_W-1:0];
      else if (addr == ADDR_W'(OFF_MODE))   rdata = DATA_W'(mode);
      else if (addr == ADDR_W'(OFF_CMD))    rdata = DATA_W'(stat);
      else if (addr == ADDR_W'(OFF_RES_HI)) rdata = res[OP_W-1:DATA_W];
      else if (addr == ADDR_W'(OFF_RES_LO)) rdata = res[DATA_W-1:0];
   end
endmodule

// File: rtl/cipher_regwrap.sv
module cipher_regwrap
   import regwrap_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   localparam int OP_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [OP_W-1:0]   eng_key,
   output logic [OP_W-1:0]   eng_din,
   output logic              eng_mode,
   output logic              eng_start,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [OP_W-1:0]   eng_dout
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover the map up to 0x2C");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must hold the status word");
   end

   logic wr;
   logic [1:0] key_we, din_we;
   logic       mode_q, done_flag;
   logic [OP_W-1:0] res_q;
   stat_t      stat;

   assign wr     = bus_sel && bus_wr;
   assign key_we = {wr && bus_addr == ADDR_W'(OFF_KEY_HI), wr && bus_addr == ADDR_W'(OFF_KEY_LO)};
   assign din_we = {wr && bus_addr == ADDR_W'(OFF_DIN_HI), wr && bus_addr == ADDR_W'(OFF_DIN_LO)};

   cipher_oppair #(.HALF_W(DATA_W)) u_key (
      .clk(clk), .rst_n(rst_n), .we(key_we), .d({bus_wdata, bus_wdata}), .q(eng_key)
   );
   cipher_oppair #(.HALF_W(DATA_W)) u_din (
      .clk(clk), .rst_n(rst_n), .we(din_we), .d({bus_wdata, bus_wdata}), .q(eng_din)
   );
   cipher_oppair #(.HALF_W(DATA_W)) u_res (
      .clk(clk), .rst_n(rst_n), .we({eng_done, eng_done}), .d(eng_dout), .q(res_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mode_q <= 1'b0;
      else if (wr && bus_addr == ADDR_W'(OFF_MODE)) mode_q <= bus_wdata[0];
   end
   assign eng_mode = mode_q;

   cipher_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (wr && bus_addr == ADDR_W'(OFF_CMD)),
      .eng_busy  (eng_busy),
      .eng_done  (eng_done),
      .start_q   (eng_start),
      .done_flag (done_flag)
   );

   assign stat.busy      = eng_busy;
   assign stat.done_seen = done_flag;

   cipher_rddec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .addr(bus_addr), .key(eng_key), .din(eng_din), .mode(mode_q),
      .stat(stat), .res(res_q), .rdata(bus_rdata)
   );
endmodule

// File: rtl/cipher_regwrap_chk.sv
module cipher_regwrap_chk
   import regwrap_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   localparam int OP_W  = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              eng_mode,
   input logic              eng_start,
   input logic              eng_busy,
   input logic              eng_done,
   input logic [OP_W-1:0]   eng_dout,
   input logic [OP_W-1:0]   res_q,
   input logic              done_flag
);
   logic cmd_wr, mode_wr, unmapped;
   assign cmd_wr  = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CMD);
   assign mode_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_MODE);
   assign unmapped = !(bus_addr == ADDR_W'(OFF_KEY_HI) || bus_addr == ADDR_W'(OFF_KEY_LO) ||
                       bus_addr == ADDR_W'(OFF_DIN_HI) || bus_addr == ADDR_W'(OFF_DIN_LO) ||
                       bus_addr == ADDR_W'(OFF_MODE)   || bus_addr == ADDR_W'(OFF_CMD)    ||
                       bus_addr == ADDR_W'(OFF_RES_HI) || bus_addr == ADDR_W'(OFF_RES_LO));

   assert_mode_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> eng_mode == $past(bus_wdata[0]));
   assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   assert_start_issued_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !eng_busy && !eng_start) |=> eng_start);
   assert_busy_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && eng_busy) |=> !eng_start);
   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> done_flag);
   assert_result_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> res_q == $past(eng_dout));
   assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_done |=> $stable(res_q));
   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && unmapped) |-> bus_rdata == '0);
endmodule

bind cipher_regwrap cipher_regwrap_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_mode(eng_mode), .eng_start(eng_start),
   .eng_busy(eng_busy), .eng_done(eng_done), .eng_dout(eng_dout), .res_q(res_q),
   .done_flag(done_flag)
);

// File: tb/sim_cipher_regwrap.sv
`timescale 1ns/1ps
module sim_cipher_regwrap;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [63:0] eng_key, eng_din, eng_dout;
   logic        eng_mode, eng_start, eng_busy, eng_done;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cipher_regwrap u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_key(eng_key), .eng_din(eng_din),
      .eng_mode(eng_mode), .eng_start(eng_start), .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_dout(eng_dout)
   );

   // behavioural engine: latency 4, encrypt = din + key, decrypt = din - key
   logic [2:0]  cnt;
   logic [63:0] calc;
   function automatic logic [63:0] model(input logic m, input logic [63:0] k, input logic [63:0] d);
      return m ? d + k : d - k;
   endfunction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_busy <= 1'b0; eng_done <= 1'b0; eng_dout <= '0; cnt <= '0; calc <= '0;
      end else begin
         eng_done <= 1'b0;
         if (eng_start) begin
            eng_busy <= 1'b1; cnt <= 3'd4; calc <= model(eng_mode, eng_key, eng_din);
         end else if (eng_busy) begin
            if (cnt == 3'd1) begin
               eng_busy <= 1'b0; eng_done <= 1'b1; eng_dout <= calc;
            end
            cnt <= cnt - 3'd1;
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic wait_done();
      logic [31:0] s;
      for (int i = 0; i < 40; i++) begin
         rd(8'h14, s);
         if (s[1]) break;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      foreach (d[i]) ;
      for (int a = 0; a < 'h30; a += 4) begin
         rd(8'(a), d);
         chk("R9 reset read", d, 0);
      end
      chk("R9 reset start", eng_start, 0);
      chk("R9 reset key", eng_key, 0);
   endtask

   task automatic t_operands();
      logic [31:0] d;
      wr(8'h00, 32'hA1B2C3D4); wr(8'h04, 32'h11223344);
      chk("R1 key packing", eng_key, 64'hA1B2C3D4_11223344);
      rd(8'h00, d); chk("R1 key hi readback", d, 32'hA1B2C3D4);
      rd(8'h04, d); chk("R1 key lo readback", d, 32'h11223344);
      wr(8'h08, 32'h00000005); wr(8'h0C, 32'hFFFFFFF0);
      chk("R2 input packing", eng_din, 64'h00000005_FFFFFFF0);
      rd(8'h0C, d); chk("R2 input lo readback", d, 32'hFFFFFFF0);
      wr(8'h10, 32'hFFFFFFFF);
      chk("R3 mode set", eng_mode, 1);
      rd(8'h10, d); chk("R3 mode readback", d, 1);
      wr(8'h10, 32'h00000002);
      chk("R3 mode clear", eng_mode, 0);
   endtask

   task automatic t_run(input logic m, input logic [63:0] k, input logic [63:0] din);
      logic [31:0] d;
      logic [63:0] exp;
      exp = model(m, k, din);
      wr(8'h00, k[63:32]); wr(8'h04, k[31:0]);
      wr(8'h08, din[63:32]); wr(8'h0C, din[31:0]);
      wr(8'h10, {31'b0, m});
      wr(8'h14, 32'h1);
      rd(8'h14, d); chk("R6 flag cleared by start", d, 0);
      chk("R4 start pulse high", eng_start, 1);
      @(negedge clk); chk("R4 start pulse one cycle", eng_start, 0);
      rd(8'h14, d); chk("R6 status busy", d, 32'h1);
      wr(8'h14, 32'h1);
      @(negedge clk); chk("R5 start while busy ignored", eng_start, 0);
      wait_done();
      rd(8'h14, d); chk("R6 status done", d, 32'h2);
      rd(8'h28, d); chk("R7 result hi", d, exp[63:32]);
      rd(8'h2C, d); chk("R7 result lo", d, exp[31:0]);
   endtask

   task automatic t_hold();
      logic [31:0] d, hi;
      rd(8'h28, hi);
      wr(8'h0C, 32'h12345678);
      wr(8'h14, 32'h1);
      @(negedge clk); @(negedge clk);
      rd(8'h28, d); chk("R7 result held during run", d, hi);
      wait_done();
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      logic [63:0] k0;
      k0 = eng_key;
      wr(8'h18, 32'hDEADBEEF); wr(8'h01, 32'hDEADBEEF); wr(8'h24, 32'hDEADBEEF);
      rd(8'h18, d); chk("R8 unmapped 0x18 zero", d, 0);
      rd(8'h01, d); chk("R8 misaligned zero", d, 0);
      rd(8'h30, d); chk("R8 unmapped 0x30 zero", d, 0);
      chk("R8 write no effect on key", eng_key, k0);
      rd(8'h14, d); chk("R8 write no effect on status", d, 32'h2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_operands();
      t_run(1'b1, 64'h01020304_05060708, 64'h10000000_F0000000);
      t_run(1'b0, 64'h00000000_00000010, 64'h00000001_00000000);
      t_hold();
      t_unmapped();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule